// File: doc/BRIEF.md
# Video Capture Window Gate and Addresser

This block sits between a video digitiser and a byte-wide frame buffer. It follows the horizontal and vertical sync pulses to know which pixel and which line each incoming 8-bit sample belongs to. It raises a rectangular gate around a region of interest and writes only the samples inside that rectangle. The writes are packed densely from address zero, so the window's top-left sample lands at address 0 and the rest follow in raster order.

A host sets the four window edges through a small register port. Edge writes go into a shadow set, which is copied into the active set at the start of every field. A window can therefore be moved at any time without tearing the field being captured. The host arms a capture with a one-cycle pulse. The next whole field is then written to memory, and a done flag rises when the following field begins. The host reads the buffer back through the same memory port. A multiplexer hands the address lines to the capture path for the whole capture, and host reads are refused while a capture is armed or running. The block also reports the registered sync level and a field-start pulse, so that the host can lock to field timing by seeing both levels of the sync.

Top module: `vwc_window_capture`

## Requirements
- R1: The pixel index is 0 in the first cycle in which hsync_i and vsync_i are both low after hsync_i was high, and it rises by one in each later cycle. The line index is 0 on the line that the first hsync_i rising edge after vsync_i opens, and it rises by one on each further hsync_i rising edge.
- R2: gate_o is high in a cycle with hsync_i and vsync_i both low exactly when left <= pixel <= right and top <= line <= bottom. Both comparisons include their end points. gate_o is low in every sync cycle and does not depend on whether a capture is running.
- R3: If left > right or top > bottom, gate_o stays low for the whole field.
- R4: A write with cfg_we_i loads cfg_wdata_i into the shadow edge selected by cfg_sel_i (0 left, 1 right, 2 top, 3 bottom). The shadow set becomes active at the next vsync_i rising edge, so a write made during a field has no effect on that field.
- R5: After an arm_i pulse in the idle state, the next field is the capture field. In that field mem_we_o equals gate_o and mem_wdata_o equals pix_i. mem_we_o is low in every other field.
- R6: The write address of the sample at pixel x and line y is (y-top)*(right-left+1)+(x-left).
- R7: done_o rises in the same cycle as the field_start_o that ends the capture field, stays high through later fields, and clears when the next capture is armed.
- R8: rd_busy_o is high from the cycle after an arm until the capture field ends. While it is high, rd_req_i produces no mem_re_o and no rd_valid_o.
- R9: When not busy, rd_req_i drives mem_re_o high and mem_addr_o to rd_addr_i in the same cycle. rd_valid_o is high RD_LAT cycles later, with rd_data_o equal to mem_rdata_i.
- R10: vs_level_o is vsync_i delayed by one cycle. field_start_o is a one-cycle pulse in the cycle after each vsync_i rising edge.
- R11: After reset, gate_o, mem_we_o, mem_re_o, rd_valid_o, rd_busy_o, done_o and field_start_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| pix_i | input | DW | Digitised sample |
| cfg_we_i | input | 1 | Shadow edge write strobe |
| cfg_sel_i | input | 2 | Edge select: 0 left, 1 right, 2 top, 3 bottom |
| cfg_wdata_i | input | CW | Edge value |
| arm_i | input | 1 | Arm a single-field capture |
| rd_req_i | input | 1 | Host read request |
| rd_addr_i | input | AW | Host read address |
| rd_data_o | output | DW | Host read data |
| rd_valid_o | output | 1 | Host read data valid |
| rd_busy_o | output | 1 | Capture armed or running; reads refused |
| done_o | output | 1 | Capture field complete |
| vs_level_o | output | 1 | Registered vertical sync level |
| field_start_o | output | 1 | One-cycle field start pulse |
| gate_o | output | 1 | Window gate for the current sample |
| mem_addr_o | output | AW | Frame buffer address |
| mem_wdata_o | output | DW | Frame buffer write data |
| mem_we_o | output | 1 | Frame buffer write enable |
| mem_re_o | output | 1 | Frame buffer read enable |
| mem_rdata_i | input | DW | Frame buffer read data |

## Verification
The bench checks the gate and the write address of every sample in a field, for several windows. These include the whole frame, a single pixel, a window against the far corner, and windows with reversed horizontal or reversed vertical edges. A comparison that leaves out an end point would drop the edge rows and columns. A row base that skips the update at a line end would make consecutive lines overwrite each other. An edge write placed in the middle of a field, under the wrong buffering, would shift the gate partway down that field. The bench also tries reads while a capture is armed and while it runs, and compares every captured byte after it is read back, so a multiplexer that lets a read through during a capture is reported.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
   typedef enum logic [1:0] {
      EDGE_LEFT   = 2'd0,
      EDGE_RIGHT  = 2'd1,
      EDGE_TOP    = 2'd2,
      EDGE_BOTTOM = 2'd3
   } edge_sel_e;
endpackage

// File: rtl/vwc_sync_track.sv
module vwc_sync_track #(
   parameter int XW = 10,
   parameter int YW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hsync_i,
   input  logic          vsync_i,
   output logic [XW-1:0] px_o,
   output logic [YW-1:0] ln_o,
   output logic          pix_cyc_o,
   output logic          hs_rise_o,
   output logic          vs_rise_o,
   output logic          vs_q_o
);
   logic hs_q;

   assign hs_rise_o = hsync_i & ~hs_q;
   assign vs_rise_o = vsync_i & ~vs_q_o;
   assign pix_cyc_o = ~hsync_i & ~vsync_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q   <= 1'b0;
         vs_q_o <= 1'b0;
         px_o   <= '0;
         ln_o   <= '1;
      end else begin
         hs_q   <= hsync_i;
         vs_q_o <= vsync_i;
         // pixel index restarts while any sync is asserted
         if (hsync_i || vsync_i) px_o <= '0;
         else                    px_o <= px_o + XW'(1);
         // line index parks one below zero during vertical sync
         if (vsync_i)        ln_o <= '1;
         else if (hs_rise_o) ln_o <= ln_o + YW'(1);
      end
   end
endmodule

// File: rtl/vwc_edge_bank.sv
module vwc_edge_bank
   import vwc_pkg::*;
#(
   parameter int XW = 10,
   parameter int YW = 10,
   localparam int CW = (XW > YW) ? XW : YW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we_i,
   input  logic [1:0]    cfg_sel_i,
   input  logic [CW-1:0] cfg_wdata_i,
   input  logic          load_i,
   output logic [XW-1:0] left_o,
   output logic [XW-1:0] right_o,
   output logic [YW-1:0] top_o,
   output logic [YW-1:0] bot_o
);
   logic [XW-1:0] sh_left, sh_right;
   logic [YW-1:0] sh_top, sh_bot;
   edge_sel_e     sel;

   assign sel = edge_sel_e'(cfg_sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_left  <= '0;
         sh_right <= '0;
         sh_top   <= '0;
         sh_bot   <= '0;
         left_o   <= '0;
         right_o  <= '0;
         top_o    <= '0;
         bot_o    <= '0;
      end else begin
         if (cfg_we_i) begin
            case (sel)
               EDGE_LEFT:   sh_left  <= cfg_wdata_i[XW-1:0];
               EDGE_RIGHT:  sh_right <= cfg_wdata_i[XW-1:0];
               EDGE_TOP:    sh_top   <= cfg_wdata_i[YW-1:0];
               EDGE_BOTTOM: sh_bot   <= cfg_wdata_i[YW-1:0];
               default: ;
            endcase
         end
         // active set takes the shadow values as they stood before this edge
         if (load_i) begin
            left_o  <= sh_left;
            right_o <= sh_right;
            top_o   <= sh_top;
            bot_o   <= sh_bot;
         end
      end
   end
endmodule

// File: rtl/vwc_span_cmp.sv
module vwc_span_cmp #(
   parameter int W = 10
) (
   input  logic [W-1:0] pos_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic         in_o
);
   // inclusive at both ends; an empty span (lo > hi) never matches
   assign in_o = (pos_i >= lo_i) && (pos_i <= hi_i);
endmodule

// File: rtl/vwc_addr_gen.sv
module vwc_addr_gen #(
   parameter int AW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          field_clr_i,
   input  logic          line_end_i,
   input  logic          wr_en_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] col;
   logic [AW-1:0] row_base;

   assign addr_o = row_base + col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col      <= '0;
         row_base <= '0;
      end else if (field_clr_i) begin
         col      <= '0;
         row_base <= '0;
      end else if (line_end_i) begin
         // a gated line has advanced col by the window width
         row_base <= row_base + col;
         col      <= '0;
      end else if (wr_en_i) begin
         col <= col + AW'(1);
      end
   end
endmodule

// File: rtl/vwc_window_capture.sv
module vwc_window_capture
   import vwc_pkg::*;
#(
   parameter int DW     = 8,
   parameter int XW     = 10,
   parameter int YW     = 10,
   parameter int AW     = 20,
   parameter int RD_LAT = 1,
   localparam int CW = (XW > YW) ? XW : YW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hsync_i,
   input  logic          vsync_i,
   input  logic [DW-1:0] pix_i,
   input  logic          cfg_we_i,
   input  logic [1:0]    cfg_sel_i,
   input  logic [CW-1:0] cfg_wdata_i,
   input  logic          arm_i,
   input  logic          rd_req_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o,
   output logic          rd_valid_o,
   output logic          rd_busy_o,
   output logic          done_o,
   output logic          vs_level_o,
   output logic          field_start_o,
   output logic          gate_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   input  logic [DW-1:0] mem_rdata_i
);
   if (DW < 1 || XW < 2 || YW < 2) begin : g_bad_dims
      $error("vwc_window_capture: DW, XW and YW too small");
   end
   if (AW < XW) begin : g_bad_aw
      $error("vwc_window_capture: AW must cover one full line");
   end
   if (RD_LAT < 1 || RD_LAT > 2) begin : g_bad_lat
      $error("vwc_window_capture: RD_LAT must be 1 or 2");
   end

   logic [XW-1:0] px, e_left, e_right;
   logic [YW-1:0] ln, e_top, e_bot;
   logic          pix_cyc, hs_rise, vs_rise, vs_q;
   logic          x_in, y_in;
   logic          armed, capturing;
   logic [AW-1:0] wr_addr;

   vwc_sync_track #(.XW(XW), .YW(YW)) u_sync (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
      .px_o(px), .ln_o(ln), .pix_cyc_o(pix_cyc), .hs_rise_o(hs_rise),
      .vs_rise_o(vs_rise), .vs_q_o(vs_q)
   );

   vwc_edge_bank #(.XW(XW), .YW(YW)) u_edges (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
      .cfg_wdata_i(cfg_wdata_i), .load_i(vs_rise),
      .left_o(e_left), .right_o(e_right), .top_o(e_top), .bot_o(e_bot)
   );

   vwc_span_cmp #(.W(XW)) u_xcmp (.pos_i(px), .lo_i(e_left), .hi_i(e_right), .in_o(x_in));
   vwc_span_cmp #(.W(YW)) u_ycmp (.pos_i(ln), .lo_i(e_top),  .hi_i(e_bot),   .in_o(y_in));

   assign gate_o = pix_cyc & x_in & y_in;

   vwc_addr_gen #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .field_clr_i(vs_rise), .line_end_i(hs_rise),
      .wr_en_i(capturing & gate_o), .addr_o(wr_addr)
   );

   // single-field capture sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed         <= 1'b0;
         capturing     <= 1'b0;
         done_o        <= 1'b0;
         field_start_o <= 1'b0;
      end else begin
         field_start_o <= vs_rise;
         if (vs_rise && capturing) begin
            capturing <= 1'b0;
            done_o    <= 1'b1;
         end else if (vs_rise && armed) begin
            capturing <= 1'b1;
            armed     <= 1'b0;
         end else if (arm_i && !rd_busy_o) begin
            armed  <= 1'b1;
            done_o <= 1'b0;
         end
      end
   end

   assign rd_busy_o  = armed | capturing;
   assign vs_level_o = vs_q;

   // memory port ownership: capture path for the whole capture field
   assign mem_addr_o  = capturing ? wr_addr : rd_addr_i;
   assign mem_we_o    = capturing & gate_o;
   assign mem_wdata_o = pix_i;
   assign mem_re_o    = rd_req_i & ~rd_busy_o;
   assign rd_data_o   = mem_rdata_i;

   if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_valid_o <= 1'b0;
         else        rd_valid_o <= mem_re_o;
      end
   end else begin : g_lat2
      logic re_d1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            re_d1      <= 1'b0;
            rd_valid_o <= 1'b0;
         end else begin
            re_d1      <= mem_re_o;
            rd_valid_o <= re_d1;
         end
      end
   end
endmodule

// File: rtl/vwc_window_capture_chk.sv
module vwc_window_capture_chk #(
   parameter int AW     = 20,
   parameter int RD_LAT = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          vsync_i,
   input logic          arm_i,
   input logic          gate_o,
   input logic          mem_we_o,
   input logic          mem_re_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          rd_busy_o,
   input logic          rd_valid_o,
   input logic          done_o,
   input logic          field_start_o
);
   // R5: a write only happens inside the gate during a capture
   p_we_in_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (gate_o && rd_busy_o));

   // R6: back-to-back writes use consecutive addresses
   p_dense_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

   // R7: done rises only together with a field start
   p_done_at_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> field_start_o);

   // R7: arming from idle clears done
   p_arm_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && !rd_busy_o) |=> !done_o);

   // R8: no memory read while busy
   p_read_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy_o |-> !mem_re_o);

   // R10: field start follows a vertical sync rise and lasts one cycle
   p_field_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync_i) |=> field_start_o);
   p_field_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      field_start_o |=> !field_start_o);

   // R9: read data valid after the configured latency
   if (RD_LAT == 1) begin : g_lat1_chk
      p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
         mem_re_o |=> rd_valid_o);
   end
endmodule

bind vwc_window_capture vwc_window_capture_chk #(.AW(AW), .RD_LAT(RD_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .arm_i(arm_i), .gate_o(gate_o),
   .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
   .rd_busy_o(rd_busy_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
   .field_start_o(field_start_o)
);

// File: tb/tb_vwc_window_capture.sv
module tb_vwc_window_capture;
   localparam int DW = 8, XW = 6, YW = 6, AW = 12, CW = 6;
   localparam int NPIX = 12, NLINES = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hsync_i = 0, vsync_i = 0, cfg_we_i = 0, arm_i = 0, rd_req_i = 0;
   logic [DW-1:0] pix_i = '0;
   logic [1:0]    cfg_sel_i = '0;
   logic [CW-1:0] cfg_wdata_i = '0;
   logic [AW-1:0] rd_addr_i = '0;
   logic [DW-1:0] rd_data_o, mem_wdata_o, mem_rdata_i;
   logic          rd_valid_o, rd_busy_o, done_o, vs_level_o, field_start_o, gate_o;
   logic          mem_we_o, mem_re_o;
   logic [AW-1:0] mem_addr_o;

   vwc_window_capture #(.DW(DW), .XW(XW), .YW(YW), .AW(AW), .RD_LAT(1)) dut (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i), .pix_i(pix_i),
      .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
      .arm_i(arm_i), .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_busy_o(rd_busy_o),
      .done_o(done_o), .vs_level_o(vs_level_o), .field_start_o(field_start_o),
      .gate_o(gate_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i)
   );

   always #10 clk = ~clk;

   // frame buffer model, one-cycle read
   logic [DW-1:0] fb [0:(1<<AW)-1];
   always @(posedge clk) begin
      if (mem_we_o) fb[mem_addr_o] <= mem_wdata_o;
      if (mem_re_o) mem_rdata_i <= fb[mem_addr_o];
   end

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   int sh[4];
   int act[4];
   int mid[4];

   task automatic check(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int sample_val(input int x, input int y);
      return ((y & 15) << 4) | (x & 15);
   endfunction

   task automatic write_edges(input int l, input int r, input int t, input int b);
      int v[4];
      v[0] = l; v[1] = r; v[2] = t; v[3] = b;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         cfg_we_i = 1; cfg_sel_i = 2'(i); cfg_wdata_i = CW'(v[i]);
         sh[i] = v[i];
      end
      @(negedge clk);
      cfg_we_i = 0;
   endtask

   task automatic run_field(input bit cap, input bit do_mid, input bit exp_done);
      int w, exp_g, exp_a;
      @(negedge clk);
      vsync_i = 1; hsync_i = 0;
      #2;
      check("R10 field_start before rise edge", int'(field_start_o), 0);
      check("R10 vs_level before rise edge", int'(vs_level_o), 0);
      act = sh;
      @(negedge clk);
      #2;
      check("R10 field_start pulse", int'(field_start_o), 1);
      check("R10 vs_level high", int'(vs_level_o), 1);
      check("R7 done at field start", int'(done_o), int'(exp_done));
      w = act[1] - act[0] + 1;
      for (int y = 0; y < NLINES; y++) begin
         @(negedge clk);
         vsync_i = 0; hsync_i = 1; cfg_we_i = 0; rd_req_i = 0;
         #2;
         check("R2 gate low in sync cycle", int'(gate_o), 0);
         if (y == 0) check("R10 field_start single cycle", int'(field_start_o), 0);
         for (int x = 0; x < NPIX; x++) begin
            @(negedge clk);
            hsync_i = 0; pix_i = DW'(sample_val(x, y));
            cfg_we_i = 0; rd_req_i = 0;
            if (do_mid && y == 2 && x < 4) begin
               cfg_we_i = 1; cfg_sel_i = 2'(x); cfg_wdata_i = CW'(mid[x]);
               sh[x] = mid[x];
            end
            if (cap && y == 1 && x == 0) begin
               rd_req_i = 1; rd_addr_i = '0;
            end
            #2;
            exp_g = (x >= act[0] && x <= act[1] && y >= act[2] && y <= act[3]) ? 1 : 0;
            check($sformatf("R1 R2 R3 R4 gate x%0d y%0d", x, y), int'(gate_o), exp_g);
            check($sformatf("R5 write enable x%0d y%0d", x, y), int'(mem_we_o), cap ? exp_g : 0);
            if (cap && exp_g == 1) begin
               exp_a = (y - act[2]) * w + (x - act[0]);
               check($sformatf("R6 write address x%0d y%0d", x, y), int'(mem_addr_o), exp_a);
               check("R5 write data", int'(mem_wdata_o), sample_val(x, y));
            end
            if (cap && y == 1 && x == 0) begin
               check("R8 busy during capture", int'(rd_busy_o), 1);
               check("R8 read refused during capture", int'(mem_re_o), 0);
            end
         end
      end
      @(negedge clk);
      cfg_we_i = 0; rd_req_i = 0; hsync_i = 0;
   endtask

   task automatic arm_capture();
      @(negedge clk);
      arm_i = 1;
      #2;
      check("R8 not busy before arm", int'(rd_busy_o), 0);
      @(negedge clk);
      arm_i = 0; rd_req_i = 1; rd_addr_i = '0;
      #2;
      check("R8 busy once armed", int'(rd_busy_o), 1);
      check("R7 done cleared by arm", int'(done_o), 0);
      check("R8 read refused while armed", int'(mem_re_o), 0);
      @(negedge clk);
      rd_req_i = 0;
      #2;
      check("R8 no read data while armed", int'(rd_valid_o), 0);
   endtask

   task automatic read_back(input int l, input int r, input int t, input int b);
      int w, n;
      if (l > r || t > b) return;
      w = r - l + 1;
      n = w * (b - t + 1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rd_req_i = 1; rd_addr_i = AW'(k);
         #2;
         check("R9 read enable", int'(mem_re_o), 1);
         check("R9 read address", int'(mem_addr_o), k);
         @(negedge clk);
         rd_req_i = 0;
         #2;
         check("R9 read valid", int'(rd_valid_o), 1);
         check($sformatf("R5 R6 R9 read data addr %0d", k), int'(rd_data_o),
               sample_val(l + k % w, t + k / w));
      end
   endtask

   initial begin
      int win[6][4];
      for (int i = 0; i < (1 << AW); i++) fb[i] = 8'hEE;
      for (int i = 0; i < 4; i++) sh[i] = 0;
      repeat (3) @(negedge clk);
      #2;
      check("R11 gate after reset", int'(gate_o), 0);
      check("R11 write enable after reset", int'(mem_we_o), 0);
      check("R11 busy after reset", int'(rd_busy_o), 0);
      @(negedge clk);
      rst_n = 1;
      #2;
      check("R11 done after reset", int'(done_o), 0);
      check("R11 read valid after reset", int'(rd_valid_o), 0);
      check("R11 field start after reset", int'(field_start_o), 0);
      check("R11 read enable after reset", int'(mem_re_o), 0);

      // double-buffered edges: a mid-field write waits for the next field
      write_edges(2, 5, 1, 3);
      run_field(0, 0, 0);
      mid[0] = 7; mid[1] = 7; mid[2] = 4; mid[3] = 4;
      run_field(0, 1, 0);
      run_field(0, 0, 0);

      // capture sweep over several windows, including empty ones (R3)
      win[0] = '{2, 5, 1, 3};
      win[1] = '{0, 11, 0, 7};
      win[2] = '{7, 7, 4, 4};
      win[3] = '{10, 11, 6, 7};
      win[4] = '{5, 3, 0, 7};
      win[5] = '{0, 11, 6, 2};
      for (int i = 0; i < 6; i++) begin
         write_edges(win[i][0], win[i][1], win[i][2], win[i][3]);
         arm_capture();
         run_field(1, 0, 0);
         run_field(0, 0, 1);
         #2;
         check("R8 idle after capture", int'(rd_busy_o), 0);
         read_back(win[i][0], win[i][1], win[i][2], win[i][3]);
      end

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got 1 expected 0 (run did not complete)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule